// File: doc/BRIEF.md
# Synchronous Burst Cache Data Memory

This block is a single-port synchronous static memory for use as the data store of a burstable cache. Each word is 18 bits, built from two 9-bit byte lanes. The depth is set by a parameter and defaults to 64 words for simulation. On each rising clock edge the block captures the address, the write data, three chip enables, two burst-start strobes, an advance strobe, a burst-order select and the write controls. Output enable is not captured and acts at once.

A burst can be opened by a processor-side strobe or by a controller-side strobe. A 2-bit counter then supplies the two low address bits for up to four beats, in either linear or interleaved order. Writes happen at the clock edge that registers them, with a per-lane mask. Reads are flow-through: the word at the registered address appears on the read port in the cycle after the edge, with no output register. A separate drive flag tells the surrounding bus logic when the read port is driving. When the flag is low, the bus is treated as high impedance.

Top module: `sbsram_top`

## Requirements
- R1: With `byte_wr_en` high, `lane_sel[0]` writes bits 8:0 and `lane_sel[1]` writes bits 17:9 of the addressed word. Unselected lanes keep their contents.
- R2: All 18 bits are written when `write_all` is high, whatever `lane_sel` and `byte_wr_en` are. All 18 bits are also written when `byte_wr_en` is high with both lane selects high.
- R3: A start loads `addr` and clears the burst counter, provided all three chip enables (`cs_main`, `cs_aux_a`, `cs_aux_b`) are high. A start is either a controller strobe or a processor strobe qualified by `cs_main`. A controller start cycle may write. A processor start cycle is always a read, even with write inputs asserted.
- R4: In a burst cycle with no start and `advance` high, the counter steps before the access. The low two address bits are (start + count) mod 4 in linear order (order bit 0), or start XOR count in interleaved order (order bit 1). The counter wraps after four beats.
- R5: A burst cycle with no start and `advance` low accesses the same address as the previous cycle.
- R6: The order bit is taken from `order_il` only at a selected start. `order_il` in later cycles of the burst has no effect.
- R7: After an edge that registers a read, `rd_data` shows the stored word at the access address. This includes data written by earlier cycles, even at the same address.
- R8: `rd_drive` is high only when the last registered cycle was a selected read and `out_en` is high now. `out_en` acts without waiting for a clock edge. A write cycle leaves `rd_drive` low in the following cycle.
- R9: A start with any chip enable low deselects the block. From the next cycle `rd_drive` is low, and burst cycles without a start cause neither write nor read until the next selected start.
- R10: A processor strobe with `cs_main` low has no effect. If no controller strobe is present, that cycle acts as an ordinary burst cycle.
- R11: After synchronous reset no burst is open and `rd_drive` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | External word address, used at a start |
| strobe_cpu | input | 1 | Processor-side burst start, qualified by cs_main |
| strobe_ctl | input | 1 | Controller-side burst start |
| advance | input | 1 | Step the burst counter in a non-start cycle |
| order_il | input | 1 | Burst order at start: 0 linear, 1 interleaved |
| cs_main | input | 1 | Chip enable, also qualifies strobe_cpu |
| cs_aux_a | input | 1 | Chip enable |
| cs_aux_b | input | 1 | Chip enable |
| wr_data | input | LANE_W*LANES | Write data, lane 0 in the low bits |
| byte_wr_en | input | 1 | Enables per-lane writes via lane_sel |
| lane_sel | input | LANES | Per-lane write selects |
| write_all | input | 1 | Writes every lane |
| out_en | input | 1 | Combinational output enable |
| rd_data | output | LANE_W*LANES | Flow-through read data |
| rd_drive | output | 1 | High when the read port drives the bus |

## Verification
The assertions assume that a burst cycle without a start follows only a selected start or another burst cycle. Before such a cycle they expect a registered access address, and they treat the counter as meaningless while no burst is open. Every cycle of the stimulus is a complete set of inputs defined in the requirements; reset is held across the first edges. The random phase keeps all three chip enables high most of the time, so bursts run for several beats. Deselects, ignored processor strobes and order changes in mid burst are still mixed in. Every word is written once before any read, so each expected read value is defined.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;

    // Decision taken for one clock edge
    typedef struct packed {
        logic start_cpu;   // processor start qualified by main enable
        logic start_any;   // any valid start
        logic selected;    // all chip enables high
        logic access;      // this edge performs a read or write
    } cycle_dec_t;

    function automatic logic [1:0] burst_low(input logic [1:0] base_lo,
                                             input logic [1:0] count,
                                             input burst_order_e ord);
        if (ord == ORD_INTERLEAVE)
            return base_lo ^ count;
        else
            return base_lo + count;
    endfunction

endpackage

// File: rtl/sbsram_burst_ctrl.sv
module sbsram_burst_ctrl
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              strobe_cpu,
    input  logic              strobe_ctl,
    input  logic              advance,
    input  logic              order_il,
    input  logic              cs_main,
    input  logic              cs_aux_a,
    input  logic              cs_aux_b,
    output cycle_dec_t        dec,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] nxt_addr
);

    localparam int HI_W = ADDR_W - 2;

    logic [ADDR_W-1:0] base_q;
    logic [1:0]        cnt_q;
    logic [1:0]        cnt_nxt;
    burst_order_e      order_q;
    logic              active_q;

    always_comb begin
        dec.start_cpu = strobe_cpu & cs_main;
        dec.start_any = dec.start_cpu | strobe_ctl;
        dec.selected  = cs_main & cs_aux_a & cs_aux_b;
        dec.access    = dec.start_any ? dec.selected : active_q;
    end

    assign cnt_nxt  = cnt_q + 2'd1;
    assign cur_addr = {base_q[ADDR_W-1:2], burst_low(base_q[1:0], cnt_q, order_q)};

    always_comb begin
        if (dec.start_any)
            nxt_addr = addr;
        else if (active_q && advance)
            nxt_addr = {base_q[ADDR_W-1:2], burst_low(base_q[1:0], cnt_nxt, order_q)};
        else
            nxt_addr = cur_addr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q   <= '0;
            cnt_q    <= '0;
            order_q  <= ORD_LINEAR;
            active_q <= 1'b0;
        end else if (dec.start_any) begin
            active_q <= dec.selected;
            if (dec.selected) begin
                base_q  <= addr;
                cnt_q   <= '0;
                order_q <= burst_order_e'(order_il);
            end
        end else if (active_q && advance) begin
            cnt_q <= cnt_nxt;
        end
    end

    logic [HI_W-1:0] unused_hi;
    assign unused_hi = base_q[ADDR_W-1:2];

    AST_START_CLEARS_COUNT: assert property (@(posedge clk) disable iff (rst)
        (dec.start_any && dec.selected) |=> (cnt_q == 2'd0 && active_q)) // R3
        else $error("start did not clear counter");

    AST_ADVANCE_STEPS: assert property (@(posedge clk) disable iff (rst)
        (!dec.start_any && active_q && advance) |=> (cnt_q == $past(cnt_q) + 2'd1)) // R4
        else $error("advance did not step counter");

    AST_HOLD_ADDRESS: assert property (@(posedge clk) disable iff (rst)
        (!dec.start_any && !advance) |=> $stable(cur_addr)) // R5
        else $error("address moved without advance");

    AST_ORDER_KEPT: assert property (@(posedge clk) disable iff (rst)
        !(dec.start_any && dec.selected) |=> $stable(order_q)) // R6
        else $error("order changed mid burst");

    AST_CPU_NEEDS_MAIN: assert property (@(posedge clk) disable iff (rst)
        (strobe_cpu && !cs_main && !strobe_ctl && !advance) |=> $stable(cur_addr)) // R10
        else $error("unqualified processor strobe took effect");

endmodule

// File: rtl/sbsram_wr_decode.sv
module sbsram_wr_decode #(
    parameter int LANES = 2
) (
    input  logic             allow,
    input  logic             byte_wr_en,
    input  logic [LANES-1:0] lane_sel,
    input  logic             write_all,
    output logic [LANES-1:0] wr_mask
);

    logic full;

    assign full = write_all | (byte_wr_en & (&lane_sel));

    always_comb begin
        if (!allow)
            wr_mask = '0;
        else if (full)
            wr_mask = '1;
        else if (byte_wr_en)
            wr_mask = lane_sel;
        else
            wr_mask = '0;
    end

endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
    parameter int ADDR_W = 6,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES-1:0]        wr_mask,
    input  logic [LANE_W*LANES-1:0] wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANE_W*LANES-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_mask[g])
                lane_mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
        end

        assign rd_data[g*LANE_W +: LANE_W] = lane_mem[rd_addr];
    end

endmodule

// File: rtl/sbsram_top.sv
module sbsram_top
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    strobe_cpu,
    input  logic                    strobe_ctl,
    input  logic                    advance,
    input  logic                    order_il,
    input  logic                    cs_main,
    input  logic                    cs_aux_a,
    input  logic                    cs_aux_b,
    input  logic [LANE_W*LANES-1:0] wr_data,
    input  logic                    byte_wr_en,
    input  logic [LANES-1:0]        lane_sel,
    input  logic                    write_all,
    input  logic                    out_en,
    output logic [LANE_W*LANES-1:0] rd_data,
    output logic                    rd_drive
);

    cycle_dec_t        dec;
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] nxt_addr;
    logic [LANES-1:0]  wr_mask;
    logic              read_q;

    sbsram_burst_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .addr      (addr),
        .strobe_cpu(strobe_cpu),
        .strobe_ctl(strobe_ctl),
        .advance   (advance),
        .order_il  (order_il),
        .cs_main   (cs_main),
        .cs_aux_a  (cs_aux_a),
        .cs_aux_b  (cs_aux_b),
        .dec       (dec),
        .cur_addr  (cur_addr),
        .nxt_addr  (nxt_addr)
    );

    sbsram_wr_decode #(.LANES(LANES)) u_wdec (
        .allow     (dec.access & ~dec.start_cpu),
        .byte_wr_en(byte_wr_en),
        .lane_sel  (lane_sel),
        .write_all (write_all),
        .wr_mask   (wr_mask)
    );

    sbsram_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_mem (
        .clk    (clk),
        .wr_addr(nxt_addr),
        .wr_mask(wr_mask),
        .wr_data(wr_data),
        .rd_addr(cur_addr),
        .rd_data(rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst)
            read_q <= 1'b0;
        else
            read_q <= dec.access & ~(|wr_mask);
    end

    assign rd_drive = read_q & out_en;

    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (dec.start_any && !dec.selected) |=> !rd_drive) // R9
        else $error("driving after deselect");

    AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (|wr_mask) |=> !rd_drive) // R8
        else $error("driving after write cycle");

    AST_CPU_START_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        dec.start_cpu |-> (wr_mask == '0)) // R3
        else $error("processor start wrote");

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> !rd_drive) // R11
        else $error("driving after reset");

endmodule

// File: tb/sim_sbsram_top.sv
module sim_sbsram_top;

    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic        strobe_cpu = 0, strobe_ctl = 0, advance = 0, order_il = 0;
    logic        cs_main = 1, cs_aux_a = 1, cs_aux_b = 1;
    logic [17:0] wr_data = '0;
    logic        byte_wr_en = 0;
    logic [1:0]  lane_sel = '0;
    logic        write_all = 0;
    logic        out_en = 0;
    logic [17:0] rd_data;
    logic        rd_drive;

    always #4 clk = ~clk;

    sbsram_top #(.ADDR_W(AW), .LANE_W(9), .LANES(2)) u0 (
        .clk(clk), .rst(rst), .addr(addr), .strobe_cpu(strobe_cpu),
        .strobe_ctl(strobe_ctl), .advance(advance), .order_il(order_il),
        .cs_main(cs_main), .cs_aux_a(cs_aux_a), .cs_aux_b(cs_aux_b),
        .wr_data(wr_data), .byte_wr_en(byte_wr_en), .lane_sel(lane_sel),
        .write_all(write_all), .out_en(out_en), .rd_data(rd_data),
        .rd_drive(rd_drive)
    );

    int n_chk  = 0;
    int n_fail = 0;

    // Reference state built from the requirements
    logic [17:0]   m [DEPTH];
    logic          m_active = 0;
    logic [AW-1:0] m_base   = '0;
    logic [1:0]    m_cnt    = '0;
    logic          m_ord    = 0;
    logic          m_read   = 0;

    function automatic logic [1:0] low_bits(input logic [1:0] s, input logic [1:0] c,
                                            input logic il);
        return il ? (s ^ c) : (s + c);
    endfunction

    function automatic logic [AW-1:0] m_cur();
        return {m_base[AW-1:2], low_bits(m_base[1:0], m_cnt, m_ord)};
    endfunction

    task automatic model_edge();
        logic sel, cpu, st, acc;
        logic [1:0] mk;
        logic [AW-1:0] a;
        sel = cs_main & cs_aux_a & cs_aux_b;
        cpu = strobe_cpu & cs_main;
        st  = cpu | strobe_ctl;
        if (st) begin
            acc = sel;
            m_active = sel;
            if (sel) begin
                m_base = addr; m_cnt = 2'd0; m_ord = order_il;
            end
        end else begin
            acc = m_active;
            if (m_active && advance) m_cnt = m_cnt + 2'd1;
        end
        mk = 2'b00;
        if (acc && !cpu) begin
            if (write_all || (byte_wr_en && lane_sel == 2'b11)) mk = 2'b11;
            else if (byte_wr_en) mk = lane_sel;
        end
        a = m_cur();
        if (mk[0]) m[a][8:0]  = wr_data[8:0];
        if (mk[1]) m[a][17:9] = wr_data[17:9];
        m_read = acc && (mk == 2'b00);
    endtask

    task automatic chk(input string tag, input logic [17:0] act, input logic [17:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive one cycle at the falling edge, model the rising edge, check at the next falling edge
    task automatic cyc(input string tag, input logic cpu, input logic ctl, input logic adv,
                       input logic [AW-1:0] a, input logic il, input logic [2:0] cs,
                       input logic be, input logic [1:0] ls, input logic wa,
                       input logic [17:0] d, input logic oe);
        logic exp_drv;
        strobe_cpu = cpu; strobe_ctl = ctl; advance = adv; addr = a; order_il = il;
        cs_main = cs[0]; cs_aux_a = cs[1]; cs_aux_b = cs[2];
        byte_wr_en = be; lane_sel = ls; write_all = wa; wr_data = d; out_en = oe;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        exp_drv = m_read & oe;
        chk(tag, {17'd0, rd_drive}, {17'd0, exp_drv});
        if (exp_drv) chk(tag, rd_data, m[m_cur()]);
    endtask

    task automatic rd(input string tag) ;
        cyc(tag, 0, 0, 0, '0, 0, 3'b111, 0, 2'b00, 0, '0, 1);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        out_en = 1'b1;
        chk("R11", {17'd0, rd_drive}, 18'd0);

        // Fill memory: four-beat linear bursts with global write, selects left low
        for (int b = 0; b < DEPTH / 4; b++)
            for (int k = 0; k < 4; k++)
                cyc("R2", 0, k == 0, k != 0, AW'(b * 4), 0, 3'b111, 0, 2'b00, 1,
                    18'(18'h2A5A5 ^ ((b * 4 + k) * 18'h0109)), 1);

        // Linear burst from low bits 2: 10,11,8,9 then wrap to 10
        cyc("R4", 0, 1, 0, 6'd10, 0, 3'b111, 0, 2'b00, 0, '0, 1);
        for (int k = 0; k < 4; k++) cyc("R4", 0, 0, 1, '0, 0, 3'b111, 0, 2'b00, 0, '0, 1);
        // Interleaved burst from low bits 1: 21,20,23,22
        cyc("R4", 0, 1, 0, 6'd21, 1, 3'b111, 0, 2'b00, 0, '0, 1);
        for (int k = 0; k < 4; k++) cyc("R4", 0, 0, 1, '0, 1, 3'b111, 0, 2'b00, 0, '0, 1);
        // Hold without advance
        rd("R5"); rd("R5");
        // Order input flipped mid burst has no effect
        cyc("R6", 0, 1, 0, 6'd31, 0, 3'b111, 0, 2'b00, 0, '0, 1);
        cyc("R6", 0, 0, 1, '0, 1, 3'b111, 0, 2'b00, 0, '0, 1);
        cyc("R6", 0, 0, 1, '0, 1, 3'b111, 0, 2'b00, 0, '0, 1);

        // Lane writes
        cyc("R1", 0, 1, 0, 6'd40, 0, 3'b111, 1, 2'b01, 0, 18'h3FFFF, 1);
        cyc("R1", 0, 1, 0, 6'd41, 0, 3'b111, 1, 2'b10, 0, 18'h3FFFF, 1);
        cyc("R2", 0, 1, 0, 6'd42, 0, 3'b111, 1, 2'b11, 0, 18'h12345, 1);
        cyc("R2", 0, 1, 0, 6'd43, 0, 3'b111, 0, 2'b00, 1, 18'h0BEEF, 1);
        cyc("R2", 0, 1, 0, 6'd40, 0, 3'b111, 0, 2'b00, 0, '0, 1);
        for (int k = 0; k < 3; k++) cyc("R1", 0, 0, 1, '0, 0, 3'b111, 0, 2'b00, 0, '0, 1);

        // Processor start with write inputs is a read
        cyc("R3", 1, 0, 0, 6'd44, 0, 3'b111, 1, 2'b11, 1, 18'h00001, 1);
        cyc("R3", 0, 1, 0, 6'd44, 0, 3'b111, 0, 2'b00, 0, '0, 1);

        // Unqualified processor strobe acts as a plain burst cycle
        cyc("R10", 1, 0, 0, 6'd50, 0, 3'b110, 0, 2'b00, 0, '0, 1);
        cyc("R10", 1, 0, 1, 6'd50, 0, 3'b110, 0, 2'b00, 0, '0, 1);

        // Deselect, then an ignored write, then read back
        cyc("R9", 0, 1, 0, 6'd12, 0, 3'b101, 0, 2'b00, 0, '0, 1);
        cyc("R9", 0, 0, 1, '0, 0, 3'b111, 0, 2'b00, 1, 18'h00000, 1);
        cyc("R9", 0, 1, 0, 6'd12, 0, 3'b111, 0, 2'b00, 0, '0, 1);
        for (int k = 0; k < 3; k++) cyc("R9", 0, 0, 1, '0, 0, 3'b111, 0, 2'b00, 0, '0, 1);

        // Output enable low blocks drive; write cycle blocks drive
        cyc("R8", 0, 1, 0, 6'd5, 0, 3'b111, 0, 2'b00, 0, '0, 0);
        rd("R8");
        cyc("R8", 0, 0, 0, '0, 0, 3'b111, 1, 2'b01, 0, 18'h1F0F0, 1);

        // Read after write at the same address
        cyc("R7", 0, 1, 0, 6'd7, 0, 3'b111, 0, 2'b00, 1, 18'h2D2D2, 1);
        cyc("R7", 1, 0, 0, 6'd7, 0, 3'b111, 0, 2'b00, 0, '0, 1);

        // Random mix
        for (int i = 0; i < 1500; i++) begin
            logic [2:0] cs;
            logic [3:0] r;
            r  = 4'($urandom_range(0, 15));
            cs = (r == 0) ? 3'($urandom_range(0, 7)) : 3'b111;
            cyc("R7", ($urandom_range(0, 7) == 0), ($urandom_range(0, 4) == 0),
                1'($urandom), AW'($urandom), 1'($urandom), cs,
                1'($urandom), 2'($urandom), ($urandom_range(0, 5) == 0),
                18'($urandom), ($urandom_range(0, 7) != 0));
        end

        finish_run();
    end

endmodule